// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block brings a 16-bit DDR SDRAM device out of power-up before the main memory controller may use it. The host writes command words, one at a time, to a single register address. Each accepted word becomes exactly one DDR command on the row-strobe, column-strobe, write-enable, bank and address pins, a fixed number of clocks after the write. Between commands the pins carry NOP.

The block checks each word against the step of the power-up sequence it expects next. The sequence is: precharge all banks, extended mode load with the DLL enabled, mode load with DLL reset, a second precharge all, two auto refreshes, and a final mode load with the DLL-reset bit cleared. A word that is unknown, or known but out of order, is dropped and sets a sticky error bit. While a command is pending, and for a minimum spacing after it issues, a busy flag refuses new writes. Once the final mode load has gone out, a done flag rises and requests from the normal controller are allowed through.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset the pins carry NOP ({ras_n,cas_n,we_n}=3'b111) with bank and address zero, and busy_o, done_o, err_o and ctrl_req_o are low.
- R2: An accepted write yields exactly one non-NOP command, exactly ISSUE_DLY clocks after the accepting clock edge, for one cycle. Encodings as {ras_n,cas_n,we_n}: precharge 3'b010, mode load 3'b000, auto refresh 3'b001, NOP 3'b111.
- R3: Word 0x17FFF issues precharge all, with address 0x1FFF (bit 10 high) and bank 2'b11.
- R4: Word 0x02002 issues a mode load to bank 2'b01 with address 0x002 (extended mode register, DLL enabled).
- R5: Word 0x00163 issues a mode load to bank 2'b00 with address 0x163 (burst 8, CAS 2.5, DLL reset). Word 0x00063 issues the same load with address 0x063.
- R6: Word 0x08000 issues auto refresh with bank and address zero.
- R7: Only the word for the current step is accepted, in the order 0x17FFF, 0x02002, 0x00163, 0x17FFF, 0x08000, 0x08000, 0x00063. A known word that arrives out of order issues nothing and sets err_o.
- R8: A word at the command address that matches no step issues nothing and sets err_o. This includes a word with any bit above bit 16 set. err_o stays high until reset.
- R9: busy_o is high from the accepting edge until MIN_GAP clocks after the command issues. A write while busy_o is high is refused: it issues nothing, sets no error and does not advance the sequence.
- R10: Writes to any register address other than CMD_REG (default 21) issue nothing and set no error.
- R11: done_o rises on the same edge that issues the final mode load and then stays high. ctrl_req_o equals ctrl_req_i while done_o is high and is low before that.
- R12: Once the seventh step has been accepted, further writes issue nothing and set no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host register write strobe |
| wr_addr_i | input | REG_AW | Host register address |
| wr_data_i | input | DATA_W | Host write data (command word) |
| ctrl_req_i | input | 1 | Request from the normal memory controller |
| ctrl_req_o | output | 1 | Request passed on once initialization is complete |
| busy_o | output | 1 | Write refused while high |
| done_o | output | 1 | Power-up sequence complete |
| err_o | output | 1 | Sticky flag for a rejected command word |
| ddr_ras_n_o | output | 1 | Row strobe, active low |
| ddr_cas_n_o | output | 1 | Column strobe, active low |
| ddr_we_n_o | output | 1 | Write enable, active low |
| ddr_ba_o | output | 2 | Bank select |
| ddr_addr_o | output | 13 | Address bus |

## Verification
The bench keeps the default ISSUE_DLY of 20 clocks, which gives 100 ns at 200 MHz. This exposes the whole pending window, so the bench can place refused writes inside it. MIN_GAP is reduced to 3 so that the end of busy falls at a distinct clock, separate from the issue clock. With these values, DATA_W=32 brings the upper-bit rejection within reach, and a 6-bit address space lets random writes to other addresses miss address 21.

// File: rtl/ddr_init_seq_pkg.sv
`timescale 1ns/1ps
package ddr_init_seq_pkg;
  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  localparam int WORD_W = 17;
  localparam int NSTEPS = 7;
  localparam int STEP_W = $clog2(NSTEPS + 1);

  typedef struct packed {
    logic            ras_n;
    logic            cas_n;
    logic            we_n;
    logic [BA_W-1:0] ba;
    logic [ADDR_W-1:0] addr;
  } ddr_cmd_t;

  localparam ddr_cmd_t CMD_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, ba: '0, addr: '0};

  localparam logic [WORD_W-1:0] W_PRE_ALL  = 17'h17FFF;
  localparam logic [WORD_W-1:0] W_EXT_MODE = 17'h02002;
  localparam logic [WORD_W-1:0] W_MODE_RST = 17'h00163;
  localparam logic [WORD_W-1:0] W_MODE_RUN = 17'h00063;
  localparam logic [WORD_W-1:0] W_REFRESH  = 17'h08000;

  // word expected at each sequence step
  function automatic logic [WORD_W-1:0] step_word(input logic [STEP_W-1:0] s);
    case (int'(s))
      0:       return W_PRE_ALL;
      1:       return W_EXT_MODE;
      2:       return W_MODE_RST;
      3:       return W_PRE_ALL;
      4:       return W_REFRESH;
      5:       return W_REFRESH;
      6:       return W_MODE_RUN;
      default: return '0;
    endcase
  endfunction

  // word layout: [16:15] opcode (10 precharge, 01 refresh, 00 mode load), [14:13] bank, [12:0] address
  function automatic ddr_cmd_t word_to_cmd(input logic [WORD_W-1:0] w);
    ddr_cmd_t c;
    c.ba   = w[14:13];
    c.addr = w[12:0];
    case (w[16:15])
      2'b10:   {c.ras_n, c.cas_n, c.we_n} = 3'b010;
      2'b01:   {c.ras_n, c.cas_n, c.we_n} = 3'b001;
      2'b00:   {c.ras_n, c.cas_n, c.we_n} = 3'b000;
      default: c = CMD_NOP;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/ddr_init_decode.sv
`timescale 1ns/1ps
module ddr_init_decode
  import ddr_init_seq_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [STEP_W-1:0] step_i,
  output logic              match_o,
  output logic              last_o,
  output ddr_cmd_t          cmd_o
);
  logic              upper_zero;
  logic [WORD_W-1:0] word;

  assign word = data_i[WORD_W-1:0];

  if (DATA_W > WORD_W) begin : g_wide
    assign upper_zero = ~|data_i[DATA_W-1:WORD_W];
  end else begin : g_exact
    assign upper_zero = 1'b1;
  end

  assign match_o = upper_zero && (step_i < STEP_W'(NSTEPS)) && (word == step_word(step_i));
  assign last_o  = (step_i == STEP_W'(NSTEPS - 1));
  assign cmd_o   = word_to_cmd(word);
endmodule

// File: rtl/ddr_init_steps.sv
`timescale 1ns/1ps
module ddr_init_steps
  import ddr_init_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              reject_i,
  input  logic              fire_last_i,
  output logic [STEP_W-1:0] step_o,
  output logic              open_o,
  output logic              done_o,
  output logic              err_o
);
  logic [STEP_W-1:0] step_q;
  logic              done_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (accept_i)    step_q <= step_q + 1'b1;
      if (reject_i)    err_q  <= 1'b1;
      if (fire_last_i) done_q <= 1'b1;
    end
  end

  assign step_o = step_q;
  assign open_o = step_q < STEP_W'(NSTEPS);
  assign done_o = done_q;
  assign err_o  = err_q;

  AST_STEP_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |=> step_o == STEP_W'($past(step_o) + 1'b1)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o); // R11
endmodule

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer
  import ddr_init_seq_pkg::*;
#(
  parameter int ISSUE_DLY = 20,
  parameter int MIN_GAP   = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     accept_i,
  input  ddr_cmd_t cmd_i,
  input  logic     last_i,
  output ddr_cmd_t cmd_o,
  output logic     busy_o,
  output logic     fire_last_o
);
  localparam int DLY_W = $clog2(ISSUE_DLY + 1);
  localparam int GAP_W = $clog2(MIN_GAP + 1);

  logic             pend_q, last_q, fire;
  logic [DLY_W-1:0] dly_q;
  logic [GAP_W-1:0] gap_q;
  ddr_cmd_t         hold_q, out_q;

  assign fire = pend_q && (dly_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      last_q <= 1'b0;
      dly_q  <= '0;
      gap_q  <= '0;
      hold_q <= CMD_NOP;
      out_q  <= CMD_NOP;
    end else begin
      out_q <= CMD_NOP;
      if (accept_i) begin
        pend_q <= 1'b1;
        dly_q  <= DLY_W'(ISSUE_DLY - 1);
        hold_q <= cmd_i;
        last_q <= last_i;
      end else if (fire) begin
        pend_q <= 1'b0;
        out_q  <= hold_q;
        gap_q  <= GAP_W'(MIN_GAP);
      end else if (pend_q) begin
        dly_q <= dly_q - 1'b1;
      end
      // spacing window counts down once the command is on the pins
      if (!fire && gap_q != '0) gap_q <= gap_q - 1'b1;
    end
  end

  assign cmd_o       = out_q;
  assign busy_o      = pend_q || (gap_q != '0);
  assign fire_last_o = fire && last_q;

  AST_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o.ras_n |=> cmd_o.ras_n && cmd_o.cas_n && cmd_o.we_n); // R2
  AST_CMD_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_o.ras_n |-> busy_o); // R9
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_i |-> !busy_o); // R9
endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
  import ddr_init_seq_pkg::*;
#(
  parameter int REG_AW    = 6,
  parameter int DATA_W    = 32,
  parameter int CMD_REG   = 21,
  parameter int ISSUE_DLY = 20,
  parameter int MIN_GAP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [REG_AW-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              ctrl_req_i,
  output logic              ctrl_req_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              ddr_ras_n_o,
  output logic              ddr_cas_n_o,
  output logic              ddr_we_n_o,
  output logic [1:0]        ddr_ba_o,
  output logic [12:0]       ddr_addr_o
);
  logic              hit, match, last, accept, reject, open, fire_last;
  logic [STEP_W-1:0] step;
  ddr_cmd_t          dec_cmd, pin_cmd;

  assign hit    = wr_en_i && (wr_addr_i == REG_AW'(CMD_REG)) && !busy_o && open;
  assign accept = hit && match;
  assign reject = hit && !match;

  ddr_init_decode #(.DATA_W(DATA_W)) u_decode (
    .data_i (wr_data_i),
    .step_i (step),
    .match_o(match),
    .last_o (last),
    .cmd_o  (dec_cmd)
  );

  ddr_init_steps u_steps (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .reject_i   (reject),
    .fire_last_i(fire_last),
    .step_o     (step),
    .open_o     (open),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  ddr_init_timer #(.ISSUE_DLY(ISSUE_DLY), .MIN_GAP(MIN_GAP)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .cmd_i      (dec_cmd),
    .last_i     (last),
    .cmd_o      (pin_cmd),
    .busy_o     (busy_o),
    .fire_last_o(fire_last)
  );

  assign ddr_ras_n_o = pin_cmd.ras_n;
  assign ddr_cas_n_o = pin_cmd.cas_n;
  assign ddr_we_n_o  = pin_cmd.we_n;
  assign ddr_ba_o    = pin_cmd.ba;
  assign ddr_addr_o  = pin_cmd.addr;
  assign ctrl_req_o  = ctrl_req_i && done_o;

  AST_REQ_HELD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_req_o |-> done_o); // R11
  AST_PRECHARGE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ddr_ras_n_o && ddr_cas_n_o && !ddr_we_n_o) |-> (ddr_addr_o[10] && ddr_ba_o == 2'b11)); // R3
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!ddr_ras_n_o && !ddr_cas_n_o && !ddr_we_n_o && ddr_addr_o == 13'h063)); // R5
endmodule

// File: tb/ddr_init_seq_bench.sv
`timescale 1ns/1ps
module ddr_init_seq_bench;
  localparam int D  = 20;
  localparam int G  = 3;
  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          req_in = 1'b1;
  logic          req_out, busy, done, err, ras_n, cas_n, we_n;
  logic [1:0]    ba;
  logic [12:0]   addr;

  always #2.5 clk = ~clk;

  ddr_init_seq #(.REG_AW(AW), .DATA_W(DW), .CMD_REG(21), .ISSUE_DLY(D), .MIN_GAP(G)) u_ddr_init_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .ctrl_req_i(req_in), .ctrl_req_o(req_out), .busy_o(busy), .done_o(done), .err_o(err),
    .ddr_ras_n_o(ras_n), .ddr_cas_n_o(cas_n), .ddr_we_n_o(we_n), .ddr_ba_o(ba), .ddr_addr_o(addr)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  int n_cmd = 0, last_cyc = -1, done_cyc = -1;
  logic [2:0]  last_rcw;
  logic [1:0]  last_ba;
  logic [12:0] last_addr;

  always @(posedge clk) cyc = cyc + 1;

  // command monitor
  always @(negedge clk) begin
    if ({ras_n, cas_n, we_n} != 3'b111) begin
      n_cmd = n_cmd + 1;
      last_cyc = cyc;
      last_rcw = {ras_n, cas_n, we_n};
      last_ba = ba;
      last_addr = addr;
    end
    if (done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] exp_cmd(input logic [16:0] w);
    case (w)
      17'h17FFF: return {3'b010, 2'b11, 13'h1FFF};
      17'h02002: return {3'b000, 2'b01, 13'h0002};
      17'h00163: return {3'b000, 2'b00, 13'h0163};
      17'h00063: return {3'b000, 2'b00, 13'h0063};
      17'h08000: return {3'b001, 2'b00, 13'h0000};
      default:   return {3'b111, 2'b00, 13'h0000};
    endcase
  endfunction

  function automatic logic [16:0] seq_word(input int s);
    case (s)
      0: return 17'h17FFF; 1: return 17'h02002; 2: return 17'h00163;
      3: return 17'h17FFF; 4: return 17'h08000; 5: return 17'h08000;
      default: return 17'h00063;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    done_cyc = -1;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, output int acc);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    acc = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // write expected to be ignored: no command within the issue window
  task automatic ignored_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input string req, input bit exp_err);
    int acc, n0;
    n0 = n_cmd;
    do_write(a, d, acc);
    repeat (D + 2) @(negedge clk);
    chk(n_cmd == n0, req, n_cmd - n0, 0);
    chk(busy == 1'b0, req, busy, 0);
    chk(err == exp_err, req, err, exp_err);
  endtask

  task automatic step_ok(input logic [16:0] w, input string req, input bit poke_busy, input logic [16:0] poke);
    int acc, n0, dummy;
    logic [17:0] e;
    @(negedge clk);
    while (busy) @(negedge clk);
    n0 = n_cmd;
    e = exp_cmd(w);
    do_write(6'd21, {15'd0, w}, acc);
    chk(busy == 1'b1, "R9 busy after accept", busy, 1);
    if (poke_busy) do_write(6'd21, {15'd0, poke}, dummy);
    while (busy) @(negedge clk);
    chk(cyc == acc + D + G, "R9 busy window", cyc - acc, D + G);
    chk(n_cmd == n0 + 1, "R2 one command", n_cmd - n0, 1);
    chk(last_cyc == acc + D, "R2 issue delay", last_cyc - acc, D);
    chk({last_rcw, last_ba, last_addr} == e, req, {last_rcw, last_ba, last_addr}, e);
  endtask

  initial begin
    int acc;
    logic [16:0] w;
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    do_reset();
    // R1
    chk({ras_n, cas_n, we_n} == 3'b111, "R1 pins NOP", {ras_n, cas_n, we_n}, 3'b111);
    chk(ba == 0 && addr == 0, "R1 bank/addr", {ba, addr}, 0);
    chk(!busy && !done && !err && !req_out, "R1 flags", {busy, done, err, req_out}, 0);

    // R10: random other addresses carrying valid words
    for (int i = 0; i < 12; i++) begin
      a = 6'($urandom % 64);
      if (a == 6'd21) a = 6'd20;
      ignored_write(a, {15'd0, seq_word(int'($urandom % 7))}, "R10 other address", 1'b0);
    end

    // full sequence: R3 R4 R5 R6 R7, with refused writes while busy (R9)
    step_ok(17'h17FFF, "R3 precharge all", 1'b1, 17'h02002);
    step_ok(17'h02002, "R4 extended mode", 1'b1, 17'h00163);
    chk(err == 1'b0, "R9 busy write no error", err, 0);
    step_ok(17'h00163, "R5 mode dll reset", 1'b0, 17'h0);
    step_ok(17'h17FFF, "R3 second precharge", 1'b0, 17'h0);
    step_ok(17'h08000, "R6 refresh 1", 1'b0, 17'h0);
    step_ok(17'h08000, "R6 refresh 2", 1'b0, 17'h0);
    chk(done == 1'b0 && req_out == 1'b0, "R11 held off", {done, req_out}, 0);
    step_ok(17'h00063, "R5 final mode", 1'b0, 17'h0);
    chk(done_cyc == last_cyc, "R11 done with final load", done_cyc - last_cyc, 0);
    chk(done && req_out, "R11 request passes", {done, req_out}, 3);
    chk(err == 1'b0, "R7 in-order no error", err, 0);

    // R12: after completion
    ignored_write(6'd21, 32'h00017FFF, "R12 after done", 1'b0);
    ignored_write(6'd21, 32'h0001ABCD, "R12 garbage after done", 1'b0);
    chk(done == 1'b1, "R11 done stays", done, 1);

    // R8: random unknown words
    do_reset();
    chk(err == 1'b0 && done == 1'b0, "R1 reset clears", {err, done}, 0);
    for (int i = 0; i < 20; i++) begin
      w = 17'($urandom);
      if (w == 17'h17FFF || w == 17'h02002 || w == 17'h00163 || w == 17'h00063 || w == 17'h08000)
        w = 17'h1ABCD;
      ignored_write(6'd21, {15'd0, w}, "R8 unknown word", i > 0 ? 1'b1 : 1'b1);
    end
    ignored_write(6'd21, 32'h00117FFF, "R8 upper bit set", 1'b1);
    step_ok(17'h17FFF, "R3 after error", 1'b0, 17'h0);
    chk(err == 1'b1, "R8 sticky", err, 1);

    // R7: out of order
    do_reset();
    ignored_write(6'd21, 32'h00008000, "R7 refresh first", 1'b1);
    step_ok(17'h17FFF, "R7 step0 still expected", 1'b0, 17'h0);
    ignored_write(6'd21, 32'h00000163, "R7 mode before ext", 1'b1);
    step_ok(17'h02002, "R4 in order after reject", 1'b0, 17'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule